// File: doc/BRIEF.md
# Data Bus Turnaround Gate

This block sits beside a DRAM command scheduler. It decides, every cycle, whether a read column command or a write column command may go out on the next clock edge. The aim is that bursts never overlap on the shared data bus. The scheduler raises `rd_issue` or `wr_issue` in the cycle it sends a column command. The block answers with `rd_ok` and `wr_ok`, which state whether each kind of command is legal at the next edge.

Spacing is worked out inside the block. Software supplies read latency, write latency, burst length, write recovery time, the column-to-column delay and a turnaround margin through a single load strobe. From these the block derives three gaps and keeps them in registers: same-direction spacing, read-to-write spacing and write-to-read spacing.

A sticky violation flag records any command that was issued while it was not allowed. A counter of direction changes lets the bus efficiency be observed.

Top module: `bus_turn_gate`

## Requirements
- R1: After reset, `rd_ok` and `wr_ok` are 1, `violation` is 0 and `switch_cnt` is 0. The configuration holds all zeros, which gives a same-direction gap of 1 and turnaround gaps of 2.
- R2: A gap of G means that a command captured at clock edge t allows the next command from edge t+G onward. The same-direction gap is max(ccd, 1), and it applies read-to-read and write-to-write.
- R3: After a read, a write is held off by a gap equal to the signed value rl + burst − wl + margin, raised to at least max(ccd, 1) and to at least 2.
- R4: When rl + burst − wl + margin is negative, the read-to-write gap becomes max(ccd, 1, 2), taken from the column delay.
- R5: After a write, a read is held off by a gap of wl + burst + wr_rec, raised to at least max(ccd, 1) and to at least 2.
- R6: A read and a write are never allowed on adjacent edges. A flag is 0 in the cycle right after a command of the other direction is captured. Asserting `rd_issue` and `wr_issue` together is a violation.
- R7: All six configuration inputs are captured on an edge e where `cfg_we` is 1. The derived gaps are recomputed on edge e+1 and govern the flags from then on.
- R8: `violation` becomes 1 at the edge that captures a read while `rd_ok` is 0, a write while `wr_ok` is 0, or both commands at once. It then stays 1 until reset.
- R9: `switch_cnt` increments, wrapping, at each edge that captures a single command whose direction differs from the last single command captured. The first command after reset does not count. A cycle with both commands asserted restarts both timers and changes neither the counter nor the remembered direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load strobe for the six configuration inputs |
| cfg_rd_lat | input | CNT_W | Read latency in cycles |
| cfg_wr_lat | input | CNT_W | Write latency in cycles |
| cfg_burst | input | CNT_W | Burst length on the bus in cycles |
| cfg_wr_rec | input | CNT_W | Write recovery time in cycles |
| cfg_ccd | input | CNT_W | Column-to-column delay in cycles |
| cfg_margin | input | CNT_W | Extra read-to-write turnaround margin |
| rd_issue | input | 1 | A read column command is sent this cycle |
| wr_issue | input | 1 | A write column command is sent this cycle |
| rd_ok | output | 1 | A read may be issued at the next edge |
| wr_ok | output | 1 | A write may be issued at the next edge |
| violation | output | 1 | Sticky flag for an illegal command |
| switch_cnt | output | SW_W | Count of direction changes |

## Verification
The embedded assertions check the following on every cycle:
- no command of the opposite direction is ever allowed on the edge right after a command;
- the violation flag is sticky, and a disallowed read or write always raises it;
- the switch counter stays still when no command is issued;
- the derived gaps change only in the cycle after a load;
- the turnaround gaps never fall below the same-direction gap.

The exact gap arithmetic can only be shown by the bench's scenarios, which compare every flag against a behavioural timeline on every clock. This covers the signed read-to-write sum and its clamp, the write-to-read sum, the two-edge delay before a new configuration takes effect, and how the direction-change count responds to mixed command patterns.

// File: rtl/bus_turn_gate.sv
module bus_turn_gate #(
  parameter int CNT_W = 8,
  parameter int SW_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CNT_W-1:0] cfg_rd_lat,
  input  logic [CNT_W-1:0] cfg_wr_lat,
  input  logic [CNT_W-1:0] cfg_burst,
  input  logic [CNT_W-1:0] cfg_wr_rec,
  input  logic [CNT_W-1:0] cfg_ccd,
  input  logic [CNT_W-1:0] cfg_margin,
  input  logic             rd_issue,
  input  logic             wr_issue,
  output logic             rd_ok,
  output logic             wr_ok,
  output logic             violation,
  output logic [SW_W-1:0]  switch_cnt
);

  localparam int GW = CNT_W + 2;
  localparam logic [GW-1:0] SAT   = '1;
  localparam logic [GW-1:0] ONE   = GW'(1);
  localparam logic [GW-1:0] TWO   = GW'(2);

  logic [CNT_W-1:0] c_rl, c_wl, c_bl, c_wr, c_ccd, c_mg;
  logic             load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_rl <= '0; c_wl <= '0; c_bl <= '0;
      c_wr <= '0; c_ccd <= '0; c_mg <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= cfg_we;
      if (cfg_we) begin
        c_rl  <= cfg_rd_lat;
        c_wl  <= cfg_wr_lat;
        c_bl  <= cfg_burst;
        c_wr  <= cfg_wr_rec;
        c_ccd <= cfg_ccd;
        c_mg  <= cfg_margin;
      end
    end
  end

  logic [GW-1:0]        ccd_eff, floor_t, wtr_sum, rtw_next, wtr_next;
  logic signed [GW:0]   rtw_raw;

  assign ccd_eff  = (c_ccd == '0) ? ONE : {2'b00, c_ccd};
  assign floor_t  = (ccd_eff > TWO) ? ccd_eff : TWO;
  assign rtw_raw  = $signed({3'b000, c_rl}) + $signed({3'b000, c_bl})
                  + $signed({3'b000, c_mg}) - $signed({3'b000, c_wl});
  assign rtw_next = (rtw_raw < $signed({1'b0, floor_t})) ? floor_t : rtw_raw[GW-1:0];
  assign wtr_sum  = {2'b00, c_wl} + {2'b00, c_bl} + {2'b00, c_wr};
  assign wtr_next = (wtr_sum < floor_t) ? floor_t : wtr_sum;

  logic [GW-1:0] gap_ccd, gap_rtw, gap_wtr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_ccd <= ONE;
      gap_rtw <= TWO;
      gap_wtr <= TWO;
    end else if (load_q) begin
      gap_ccd <= ccd_eff;
      gap_rtw <= rtw_next;
      gap_wtr <= wtr_next;
    end
  end

  logic [GW-1:0] since_rd, since_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rd <= SAT;
      since_wr <= SAT;
    end else begin
      if (rd_issue)              since_rd <= ONE;
      else if (since_rd != SAT)  since_rd <= since_rd + ONE;
      if (wr_issue)              since_wr <= ONE;
      else if (since_wr != SAT)  since_wr <= since_wr + ONE;
    end
  end

  assign rd_ok = (since_rd >= gap_ccd) && (since_wr >= gap_wtr);
  assign wr_ok = (since_wr >= gap_ccd) && (since_rd >= gap_rtw);

  logic have_last, last_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      violation  <= 1'b0;
      switch_cnt <= '0;
      have_last  <= 1'b0;
      last_wr    <= 1'b0;
    end else begin
      if ((rd_issue && !rd_ok) || (wr_issue && !wr_ok) || (rd_issue && wr_issue))
        violation <= 1'b1;
      if (rd_issue ^ wr_issue) begin
        have_last <= 1'b1;
        last_wr   <= wr_issue;
        if (have_last && (last_wr != wr_issue))
          switch_cnt <= switch_cnt + 1'b1;
      end
    end
  end

  p_no_b2b_rw_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |=> !wr_ok);
  p_no_b2b_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_issue |=> !rd_ok);
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> violation);
  p_bad_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_issue && !rd_ok) |=> violation);
  p_bad_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_issue && !wr_ok) |=> violation);
  p_sw_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_issue || wr_issue) |=> $stable(switch_cnt));
  p_gap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_q |=> ($stable(gap_rtw) && $stable(gap_wtr) && $stable(gap_ccd)));
  p_rtw_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_rtw >= gap_ccd) && (gap_wtr >= gap_ccd) && (gap_rtw >= TWO));

endmodule

// File: tb/test_bus_turn_gate.sv
module test_bus_turn_gate;
  localparam int CNT_W = 8;
  localparam int SW_W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [CNT_W-1:0] cfg_rd_lat = '0, cfg_wr_lat = '0, cfg_burst = '0;
  logic [CNT_W-1:0] cfg_wr_rec = '0, cfg_ccd = '0, cfg_margin = '0;
  logic rd_issue = 1'b0, wr_issue = 1'b0;
  logic rd_ok, wr_ok, violation;
  logic [SW_W-1:0] switch_cnt;

  always #2.5 clk = ~clk;

  bus_turn_gate #(.CNT_W(CNT_W), .SW_W(SW_W)) i_bus_turn_gate (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .cfg_rd_lat(cfg_rd_lat), .cfg_wr_lat(cfg_wr_lat), .cfg_burst(cfg_burst),
    .cfg_wr_rec(cfg_wr_rec), .cfg_ccd(cfg_ccd), .cfg_margin(cfg_margin),
    .rd_issue(rd_issue), .wr_issue(wr_issue),
    .rd_ok(rd_ok), .wr_ok(wr_ok), .violation(violation), .switch_cnt(switch_cnt));

  int errors = 0, checks = 0;
  bit done = 0;
  string cur = "R1 reset";

  int n, t_rd, t_wr, g_ccd, g_rtw, g_wtr, m_sw;
  int c_rl, c_wl, c_bl, c_wr, c_ccd, c_mg;
  bit m_viol, have, last_wr;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic bit exp_rd();
    return (n - t_rd + 1 >= g_ccd) && (n - t_wr + 1 >= g_wtr);
  endfunction

  function automatic bit exp_wr();
    return (n - t_wr + 1 >= g_ccd) && (n - t_rd + 1 >= g_rtw);
  endfunction

  task automatic model_reset();
    n = 0; t_rd = -100000; t_wr = -100000;
    g_ccd = 1; g_rtw = 2; g_wtr = 2; m_sw = 0;
    c_rl = 0; c_wl = 0; c_bl = 0; c_wr = 0; c_ccd = 0; c_mg = 0;
    m_viol = 0; have = 0; last_wr = 0;
  endtask

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] at cycle %0d: actual=%0d expected=%0d", what, cur, n, act, exp);
    end
  endtask

  task automatic check_all();
    cmp("rd_ok R2 R5 R6", int'(rd_ok), int'(exp_rd()));
    cmp("wr_ok R2 R3 R6", int'(wr_ok), int'(exp_wr()));
    cmp("violation R8", int'(violation), int'(m_viol));
    cmp("switch_cnt R9", int'(switch_cnt), m_sw % (1 << SW_W));
  endtask

  task automatic model_edge(bit rd, bit wr, bit we);
    int fl, nccd;
    if ((rd && !exp_rd()) || (wr && !exp_wr()) || (rd && wr)) m_viol = 1;
    if (rd ^ wr) begin
      if (have && (last_wr != wr)) m_sw++;
      have = 1; last_wr = wr;
    end
    nccd = imax(c_ccd, 1);
    fl = imax(nccd, 2);
    g_ccd = nccd;
    g_rtw = imax(c_rl + c_bl - c_wl + c_mg, fl);
    g_wtr = imax(c_wl + c_bl + c_wr, fl);
    if (we) begin
      c_rl = cfg_rd_lat; c_wl = cfg_wr_lat; c_bl = cfg_burst;
      c_wr = cfg_wr_rec; c_ccd = cfg_ccd; c_mg = cfg_margin;
    end
    n++;
    if (rd) t_rd = n;
    if (wr) t_wr = n;
  endtask

  task automatic step(bit rd, bit wr, bit we = 0);
    check_all();
    rd_issue = rd; wr_issue = wr; cfg_we = we;
    model_edge(rd, wr, we);
    @(posedge clk);
    @(negedge clk);
    rd_issue = 0; wr_issue = 0; cfg_we = 0;
  endtask

  task automatic load(int rl, int wl, int bl, int wr, int ccd, int mg);
    cfg_rd_lat = CNT_W'(rl); cfg_wr_lat = CNT_W'(wl); cfg_burst = CNT_W'(bl);
    cfg_wr_rec = CNT_W'(wr); cfg_ccd = CNT_W'(ccd); cfg_margin = CNT_W'(mg);
    step(0, 0, 1);
    step(0, 0, 0);
  endtask

  task automatic issue(bit wr);
    for (int k = 0; k < 2000; k++) begin
      if (wr ? exp_wr() : exp_rd()) break;
      step(0, 0);
    end
    if (wr) step(0, 1); else step(1, 0);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur = "R1 reset values";
    check_all();

    cur = "R2 default spacing";
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    cur = "R6 default turnaround";
    step(0, 1); step(0, 0); step(1, 0); step(0, 0); step(0, 0);

    cur = "R7 load and R3 R5 sums";
    load(10, 6, 4, 5, 4, 2);
    issue(0); issue(0); issue(1); issue(1); issue(0); issue(1); issue(0);
    for (int k = 0; k < 20; k++) step(0, 0);

    cur = "R4 negative clamp to ccd";
    load(2, 9, 2, 0, 3, 0);
    issue(0); issue(1); issue(0); issue(1);
    cur = "R4 negative clamp, ccd below two";
    load(1, 12, 1, 1, 1, 0);
    issue(0); issue(1); issue(1); issue(0);

    cur = "R7 change while a gap is running";
    load(20, 2, 8, 0, 2, 3);
    step(1, 0);
    load(0, 0, 0, 0, 0, 0);
    issue(1); issue(0);

    for (int s = 0; s < 25; s++) begin
      cur = "R2 R3 R5 R9 sweep";
      load($urandom_range(0, 20), $urandom_range(0, 20), $urandom_range(0, 16),
           $urandom_range(0, 15), $urandom_range(0, 8), $urandom_range(0, 6));
      for (int k = 0; k < 12; k++) issue(bit'($urandom_range(0, 1)));
    end

    cur = "R8 early read sets violation";
    load(4, 2, 4, 3, 4, 1);
    step(1, 0); step(1, 0);
    for (int k = 0; k < 30; k++) step(0, 0);
    cur = "R8 violation stays set";
    issue(1); issue(0);
    cur = "R6 simultaneous commands";
    for (int k = 0; k < 30; k++) step(0, 0);
    step(1, 1);
    for (int k = 0; k < 30; k++) step(0, 0);
    issue(0);
    check_all();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog [%s]: actual=hung expected=finished", cur);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule